// File: doc/BRIEF.md
# Handshake DMA Request Budget Controller

This block tracks requests for a memory-to-memory DMA channel driven by an external handshake. An outside device toggles an asynchronous request line. The block synchronizes that line and counts its significant edges, either rising or falling as configured, into a signed pending-request budget. It then launches fixed-length blocks on a downstream transfer engine. The engine reports every finished transfer with a one-cycle pulse. The block keeps a live count of the transfers left in the current block. When that count reaches zero, it closes the block and takes one request out of the budget.

The budget is preloaded from a configuration value on each rising edge of the enable bit. A positive preload launches that many blocks with no request activity. A negative preload makes the block swallow that many request edges before it starts any block. Configuration inputs set the budget preload, the block length, the edge polarity and the enable. A strobe reloads the live block count while the block is idle. Both live counters are visible on output ports.

Top module: `hs_req_budget`

## Requirements
- R1: While reset is high and in the cycle after it, the budget count, the block count, busy, the start pulse and the done pulse all read zero.
- R2: The request input passes through two synchronizing flops. With cfg_fall_edge = 0 a 0-to-1 change counts; with 1 a 1-to-0 change counts. While cfg_enable is high, each counted edge raises the budget by one on the third rising clock edge after the change. Edges of the other polarity, and all edges while cfg_enable is low, have no effect.
- R3: At the clock edge where cfg_enable is first seen high after being low, the budget loads cfg_ecinit. This load overrides any edge or completion in that cycle.
- R4: A positive preload starts blocks with the request input held still, one block per unit of budget.
- R5: A block starts only in a cycle where cfg_enable is high and was high in the previous cycle, busy is low and the budget is greater than zero. At the next edge busy rises and blk_start_o is high for exactly that one cycle.
- R6: When a block starts, the block count loads cfg_bcinit. Each xfer_done seen while busy with a nonzero block count lowers it by one. xfer_done while idle has no effect.
- R7: When busy is high and the block count is zero, the next edge clears busy, pulses blk_done_o for one cycle and lowers the budget by one. The block count stays zero. A cfg_bcinit of zero gives a block that completes one cycle after it starts.
- R8: A negative budget (bit 15 set, two's complement) rises toward zero with each counted edge and launches nothing. A preload of -N therefore absorbs N edges.
- R9: The budget does not wrap. An increment at +32767 (16'h7FFF) holds the value, and a decrement at -32768 (16'h8000) holds it.
- R10: A cfg_rbc pulse reloads the block count from cfg_bcinit only when cfg_enable is high and busy is low. Otherwise the pulse is ignored.
- R11: A counted edge and a block completion that take effect at the same edge leave the budget unchanged.
- R12: blk_start_o and blk_done_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | 1 | Asynchronous request line from the external device |
| cfg_enable | input | 1 | Handshake enable; its rising edge reloads the budget |
| cfg_fall_edge | input | 1 | 0: rising edges count, 1: falling edges count |
| cfg_ecinit | input | 16 | Budget preload, two's complement |
| cfg_bcinit | input | 16 | Block length in transfers, unsigned |
| cfg_rbc | input | 1 | Reload strobe for the block count |
| xfer_done | input | 1 | One pulse per transfer finished by the engine |
| blk_start_o | output | 1 | One-cycle pulse when a block is launched |
| busy_o | output | 1 | High while a block is in progress |
| blk_done_o | output | 1 | One-cycle pulse when a block completes |
| ecount_o | output | 16 | Live budget, two's complement |
| bcount_o | output | 16 | Live count of transfers left in the block |

## Verification
A counted request edge and the closing of a block can both act on the budget at the same clock edge. To make that happen on purpose, the bench raises the request line one cycle before it gives the final xfer_done of a one-transfer block. The synchronizer delay then lines the edge up with the completion. The bench expects the budget to hold its value while blk_done_o pulses. Random traffic, with short blocks and a dense request toggle, hits the same coincidence many more times. A reference model in the bench follows the requirement rules and judges every cycle.

// File: rtl/hsb_pkg.sv
package hsb_pkg;
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_pol_e;
endpackage

// File: rtl/hsb_req_sync.sv
module hsb_req_sync #(
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  hsb_pkg::edge_pol_e pol_i,
  output logic              edge_o
);
  logic [STAGES-1:0] chain;
  logic              prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 1'b0;
        else     chain[g] <= req_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 1'b0;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain[STAGES-1];
  end

  always_comb begin
    if (pol_i == hsb_pkg::EDGE_FALL) edge_o = prev_q & ~chain[STAGES-1];
    else                             edge_o = ~prev_q & chain[STAGES-1];
  end

  // R2
  edge_single_chk: assert property (@(posedge clk) disable iff (rst)
    edge_o |=> (!edge_o || !$stable(pol_i)));
endmodule

// File: rtl/hsb_edge_counter.sv
module hsb_edge_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         inc_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] CNT_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] CNT_MIN = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (inc_i && !dec_i) begin
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end else if (dec_i && !inc_i) begin
      if (cnt_q != CNT_MIN) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o = cnt_q;

  // R3
  preload_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |=> cnt_q == $past(load_val_i));
  // R9
  no_wrap_up_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_i && inc_i && !dec_i && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);
  // R9
  no_wrap_down_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_i && dec_i && !inc_i && cnt_q == CNT_MIN) |=> cnt_q == CNT_MIN);
  // R11
  tie_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_i && inc_i && dec_i) |=> $stable(cnt_q));
endmodule

// File: rtl/hsb_block_counter.sv
module hsb_block_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic         xfer_done_i,
  input  logic         rbc_i,
  input  logic         enable_i,
  input  logic [W-1:0] bcinit_i,
  output logic [W-1:0] bcount_o,
  output logic         busy_o,
  output logic         done_o
);
  logic [W-1:0] bcount_q;
  logic         busy_q;
  logic         last_c;

  assign last_c = busy_q && (bcount_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      bcount_q <= '0;
      busy_q   <= 1'b0;
    end else if (start_i) begin
      bcount_q <= bcinit_i;
      busy_q   <= 1'b1;
    end else if (last_c) begin
      busy_q   <= 1'b0;
    end else if (busy_q && xfer_done_i) begin
      bcount_q <= bcount_q - 1'b1;
    end else if (rbc_i && enable_i && !busy_q) begin
      bcount_q <= bcinit_i;
    end
  end

  assign bcount_o = bcount_q;
  assign busy_o   = busy_q;
  assign done_o   = last_c;

  // R6
  launch_load_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (busy_q && bcount_q == $past(bcinit_i)));
  // R7
  close_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && bcount_q == '0) |=> (!busy_q && bcount_q == '0));
  // R10
  rbc_busy_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (rbc_i && busy_q && !xfer_done_i) |=> $stable(bcount_q));
endmodule

// File: rtl/hs_req_budget.sv
module hs_req_budget #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_in,
  input  logic             cfg_enable,
  input  logic             cfg_fall_edge,
  input  logic [CNT_W-1:0] cfg_ecinit,
  input  logic [CNT_W-1:0] cfg_bcinit,
  input  logic             cfg_rbc,
  input  logic             xfer_done,
  output logic             blk_start_o,
  output logic             busy_o,
  output logic             blk_done_o,
  output logic [CNT_W-1:0] ecount_o,
  output logic [CNT_W-1:0] bcount_o
);
  logic             en_q;
  logic             req_edge;
  logic             ec_load;
  logic             ec_inc;
  logic             blk_last;
  logic             launch;
  logic             ec_positive;
  logic [CNT_W-1:0] ec_val;
  logic             busy_w;

  hsb_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .req_i  (req_in),
    .pol_i  (hsb_pkg::edge_pol_e'(cfg_fall_edge)),
    .edge_o (req_edge)
  );

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= cfg_enable;
  end

  assign ec_load     = cfg_enable && !en_q;
  assign ec_inc      = cfg_enable && req_edge;
  assign ec_positive = !ec_val[CNT_W-1] && (ec_val != '0);
  assign launch      = cfg_enable && en_q && !busy_w && ec_positive;

  hsb_edge_counter #(.W(CNT_W)) u_ecnt (
    .clk        (clk),
    .rst        (rst),
    .load_i     (ec_load),
    .load_val_i (cfg_ecinit),
    .inc_i      (ec_inc),
    .dec_i      (blk_last),
    .cnt_o      (ec_val)
  );

  hsb_block_counter #(.W(CNT_W)) u_bcnt (
    .clk         (clk),
    .rst         (rst),
    .start_i     (launch),
    .xfer_done_i (xfer_done),
    .rbc_i       (cfg_rbc),
    .enable_i    (cfg_enable),
    .bcinit_i    (cfg_bcinit),
    .bcount_o    (bcount_o),
    .busy_o      (busy_w),
    .done_o      (blk_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_start_o <= 1'b0;
      blk_done_o  <= 1'b0;
    end else begin
      blk_start_o <= launch;
      blk_done_o  <= blk_last;
    end
  end

  assign busy_o   = busy_w;
  assign ecount_o = ec_val;

  // R5
  launch_gate_chk: assert property (@(posedge clk) disable iff (rst)
    blk_start_o |-> ($past(ec_positive) && busy_w && $past(en_q)));
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    blk_done_o |-> !busy_w);
  // R12
  start_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(blk_start_o && blk_done_o));
endmodule

// File: tb/test_hs_req_budget.sv
module test_hs_req_budget;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] MAXV = 16'h7FFF;
  localparam logic [15:0] MINV = 16'h8000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_in = 1'b0, cfg_enable = 1'b0, cfg_fall_edge = 1'b0;
  logic [15:0] cfg_ecinit = '0, cfg_bcinit = '0;
  logic cfg_rbc = 1'b0, xfer_done = 1'b0;
  logic blk_start_o, busy_o, blk_done_o;
  logic [15:0] ecount_o, bcount_o;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hs_req_budget i_hs_req_budget (
    .clk(clk), .rst(rst), .req_in(req_in), .cfg_enable(cfg_enable),
    .cfg_fall_edge(cfg_fall_edge), .cfg_ecinit(cfg_ecinit), .cfg_bcinit(cfg_bcinit),
    .cfg_rbc(cfg_rbc), .xfer_done(xfer_done), .blk_start_o(blk_start_o),
    .busy_o(busy_o), .blk_done_o(blk_done_o), .ecount_o(ecount_o), .bcount_o(bcount_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Reference model built from the requirements
  logic m_s1, m_s2, m_s3, m_enq, m_busy, m_st, m_dn;
  logic [15:0] m_ec, m_bc;
  logic e_v, d_v, s_v, inc_v;

  function automatic logic positive(input logic [15:0] v);
    return !v[15] && v != 16'h0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_s1 <= 0; m_s2 <= 0; m_s3 <= 0; m_enq <= 0; m_busy <= 0;
      m_st <= 0; m_dn <= 0; m_ec <= '0; m_bc <= '0;
    end else begin
      e_v   = cfg_fall_edge ? (m_s3 & ~m_s2) : (~m_s3 & m_s2);
      inc_v = cfg_enable && e_v;
      d_v   = m_busy && m_bc == 16'h0;
      s_v   = cfg_enable && m_enq && !m_busy && positive(m_ec);
      m_s1 <= req_in; m_s2 <= m_s1; m_s3 <= m_s2; m_enq <= cfg_enable;
      if (cfg_enable && !m_enq) m_ec <= cfg_ecinit;
      else if (inc_v && !d_v) begin if (m_ec != MAXV) m_ec <= m_ec + 1; end
      else if (d_v && !inc_v) begin if (m_ec != MINV) m_ec <= m_ec - 1; end
      if (s_v) begin m_bc <= cfg_bcinit; m_busy <= 1; end
      else if (d_v) m_busy <= 0;
      else if (m_busy && xfer_done) m_bc <= m_bc - 1;
      else if (cfg_rbc && cfg_enable && !m_busy) m_bc <= cfg_bcinit;
      m_st <= s_v; m_dn <= d_v;
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R2 R3 R8 R9 R11 model budget", ecount_o, m_ec);
      chk("R6 R10 model block count", bcount_o, m_bc);
      chk("R5 R7 model busy", busy_o, m_busy);
      chk("R5 model start", blk_start_o, m_st);
      chk("R7 model done", blk_done_o, m_dn);
      chk("R12 start/done exclusive", blk_start_o && blk_done_o, 0);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfers(input int n);
    for (int i = 0; i < n; i++) begin
      xfer_done = 1'b1; tick(1); xfer_done = 1'b0;
    end
  endtask

  task automatic pulse_req;
    req_in = ~req_in; tick(2); req_in = ~req_in; tick(2);
  endtask

  initial begin
    void'($urandom(32'd2024));
    tick(3);
    chk("R1 budget in reset", ecount_o, 0);
    chk("R1 count in reset", bcount_o, 0);
    chk("R1 busy in reset", busy_o, 0);
    rst = 1'b0;
    tick(1);
    chk("R1 start after reset", blk_start_o, 0);

    // Positive preload, no request activity
    cfg_bcinit = 16'd3; cfg_ecinit = 16'd2; cfg_enable = 1'b1;
    tick(1);
    chk("R3 preload", ecount_o, 2);
    tick(1);
    chk("R4 auto start busy", busy_o, 1);
    chk("R6 count loaded", bcount_o, 3);
    xfers(3);
    chk("R6 count reaches zero", bcount_o, 0);
    tick(1);
    chk("R7 done pulse", blk_done_o, 1);
    chk("R7 budget decremented", ecount_o, 1);
    tick(1);
    chk("R4 second block starts", blk_start_o, 1);
    xfers(3); tick(4);
    chk("R4 budget drained", ecount_o, 0);
    chk("R4 idle after drain", busy_o, 0);
    xfers(1);
    chk("R6 idle xfer ignored", bcount_o, 0);

    // Negative preload absorbs edges
    cfg_enable = 1'b0; tick(1);
    cfg_ecinit = 16'hFFFE; cfg_enable = 1'b1; tick(1);
    chk("R8 negative preload", ecount_o, 16'hFFFE);
    pulse_req(); pulse_req(); tick(3);
    chk("R8 edges absorbed", ecount_o, 0);
    chk("R8 nothing launched", busy_o, 0);
    cfg_bcinit = 16'd5; cfg_rbc = 1'b1; tick(1); cfg_rbc = 1'b0;
    chk("R10 idle reload", bcount_o, 5);
    pulse_req(); tick(2);
    chk("R8 launch after budget positive", busy_o, 1);
    cfg_bcinit = 16'd9; cfg_rbc = 1'b1; tick(1); cfg_rbc = 1'b0;
    chk("R10 reload ignored while busy", bcount_o, 5);
    xfers(5); tick(3);
    chk("R7 block closed", busy_o, 0);

    // Falling-edge polarity
    cfg_enable = 1'b0; req_in = 1'b1; tick(4);
    cfg_fall_edge = 1'b1; cfg_ecinit = 16'd0; cfg_enable = 1'b1; tick(2);
    chk("R2 no edge counted on setup", ecount_o, 0);
    req_in = 1'b0; tick(2); req_in = 1'b1; tick(2); tick(2);
    chk("R2 falling edge counted once", ecount_o, 1);
    chk("R2 falling edge launches", busy_o, 1);
    xfers(9); tick(3);
    chk("R2 drained", ecount_o, 0);
    cfg_fall_edge = 1'b0; req_in = 1'b0; tick(4);

    // Edge and completion coincide
    cfg_bcinit = 16'd1;
    pulse_req(); tick(2);
    chk("R11 setup busy", busy_o, 1);
    req_in = 1'b1; tick(1);
    xfer_done = 1'b1; tick(1); xfer_done = 1'b0;
    tick(1);
    chk("R11 budget held", ecount_o, 1);
    chk("R11 done seen", blk_done_o, 1);
    req_in = 1'b0; tick(2); xfers(1); tick(4);
    chk("R11 drained", ecount_o, 0);

    // Saturation at both ends
    cfg_enable = 1'b0; tick(1);
    cfg_ecinit = MAXV; cfg_bcinit = 16'd200; cfg_enable = 1'b1; tick(3);
    chk("R9 busy at max", busy_o, 1);
    pulse_req(); tick(3);
    chk("R9 hold at max", ecount_o, MAXV);
    cfg_enable = 1'b0; tick(1);
    cfg_ecinit = MINV; cfg_enable = 1'b1; tick(1);
    chk("R9 min preload", ecount_o, MINV);
    xfers(200); tick(3);
    chk("R9 hold at min", ecount_o, MINV);
    chk("R9 idle", busy_o, 0);

    // Random traffic
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(63) == 0) begin
        cfg_enable = ~cfg_enable;
        cfg_ecinit = 16'($signed($urandom_range(6)) - 3);
      end
      if ($urandom_range(127) == 0) cfg_fall_edge = ~cfg_fall_edge;
      if ($urandom_range(3) == 0) req_in = ~req_in;
      xfer_done = $urandom_range(1) == 1;
      cfg_rbc = $urandom_range(15) == 0;
      cfg_bcinit = 16'($urandom_range(4));
      tick(1);
    end
    xfer_done = 1'b0; cfg_rbc = 1'b0;
    tick(2);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule